// File: doc/BRIEF.md
# Strobed Input Port with Programmable Second Handshake

This block is an 8-bit parallel input port for a peripheral that presents bytes together with a strobe. Each rising edge of the strobe pin captures one byte into a two-entry holding buffer. A bus master reads the bytes back in arrival order through a small register interface. A status bit tells the master whether any unread byte is waiting. Both external pins pass through a synchronizer into the system clock domain, and edges are detected there.

The second handshake pin, called the auxiliary pin, works in one of four ways chosen by a 2-bit mode field:

- **Edge input.** A rising edge on the pin sets a sticky status bit.
- **Fixed low.** The pin is driven low at all times.
- **Fixed high.** The pin is driven high at all times.
- **Interlocked ready.** The pin is high while the buffer can accept a byte. It drops for at least one clock after every accepted strobe. It stays low while both entries are full. Strobes that arrive while it is low are ignored.

An enable bit gates the auxiliary status and the interlocked ready output.

**Register map** (`reg_sel_i`):

| Select | Name | Access | Contents |
|---|---|---|---|
| 0 | control | read/write | bit 7 = enable, bits 1:0 = mode (0 edge input, 1 fixed low, 2 fixed high, 3 interlocked) |
| 1 | status | read; write 1 to bit 1 clears it | bit 0 = unread data present, bit 1 = auxiliary edge status |
| 2 | data | read | oldest unread byte; a read strobe removes it |
| 3 | unused | read | reads 0 |

**Timing.** The data pins are sampled at the first clock edge after the strobe rises. The captured byte becomes visible no later than the third clock edge after the strobe rises.

Top module: `hsk_in_port`

## Requirements
- R1: After reset the control register reads 0 (enable off, edge-input mode), the status register reads 0, and `aux_oe_o` is 0.
- R2: A rising edge on `strb_i` captures `strb_data_i`. Within three clock edges, status bit 0 reads 1 and the byte is readable at select 2.
- R3: Captured bytes are returned oldest first. The buffer holds two bytes. Status bit 0 returns to 0 when the last unread byte is read.
- R4: A data read with the buffer empty returns the byte most recently read and changes no status.
- R5: Outside interlocked mode, a strobe that arrives while both entries are full is dropped, and the stored bytes are unchanged.
- R6: In edge-input mode with enable set, a rising edge on `aux_i` sets status bit 1. Writing 1 to status bit 1 clears it. Writing 0 leaves it unchanged.
- R7: While enable is 0, status bit 1 reads 0 and auxiliary edges do not set it.
- R8: In fixed-low mode `aux_o` is 0, and in fixed-high mode `aux_o` is 1. In both modes `aux_oe_o` is 1 and status bit 1 reads 0 even after auxiliary edges.
- R9: In interlocked mode with enable set, `aux_o` is 1 while fewer than two bytes are held. It goes to 0 in the clock after each accepted strobe. It stays 0 while both entries are full, and returns to 1 after a data read removes a byte.
- R10: In interlocked mode, strobes that arrive while `aux_o` is 0 are ignored.
- R11: In interlocked mode with enable 0, `aux_o` is held at 0.
- R12: The control register reads back the enable bit and the mode field as written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| strb_i | input | 1 | Strobe pin; rising edge captures a byte |
| strb_data_i | input | 8 | Parallel data pins |
| aux_i | input | 1 | Auxiliary pin as an input (edge-input mode) |
| aux_o | output | 1 | Auxiliary pin output value |
| aux_oe_o | output | 1 | Auxiliary pin output enable (1 in all output modes) |
| reg_sel_i | input | 2 | Register select: 0 control, 1 status, 2 data |
| reg_rd_i | input | 1 | Read strobe; at select 2 it removes the oldest byte |
| reg_wr_i | input | 1 | Write strobe |
| reg_wdata_i | input | 8 | Write data |
| reg_rdata_o | output | 8 | Read data for the selected register |

## Verification
The assertions check several properties on every cycle:

- The buffer never holds more than two bytes.
- Stored bytes stay unchanged while the buffer is full and no read happens.
- A read of an empty buffer changes nothing.
- The ready output falls after every accepted strobe.
- Disable clears both the auxiliary status and the ready output.
- In interlocked mode, no strobe is taken while ready is low.

Only the bench scenarios can show the end-to-end behaviour at the ports:

- bytes come back in arrival order;
- an overflowing byte is really lost;
- the write-one-to-clear rule holds;
- the fixed-output levels are correct;
- the ready pin rises again after a read frees an entry.

// File: rtl/hsk_in_pkg.sv
package hsk_in_pkg;

  typedef enum logic [1:0] {
    AUX_EDGE_IN   = 2'b00,
    AUX_FIX_LO    = 2'b01,
    AUX_FIX_HI    = 2'b10,
    AUX_INTERLOCK = 2'b11
  } aux_mode_e;

  localparam logic [1:0] SEL_CTRL = 2'd0;
  localparam logic [1:0] SEL_STAT = 2'd1;
  localparam logic [1:0] SEL_DATA = 2'd2;

  localparam int CTRL_EN_BIT  = 7;
  localparam int STAT_DP_BIT  = 0;
  localparam int STAT_AUX_BIT = 1;

endpackage

// File: rtl/hsk_in_sync.sv
// Multi-stage pin synchronizer with rising-edge detection, one lane per pin.
module hsk_in_sync #(
  parameter int N_PINS = 2,
  parameter int STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_PINS-1:0] pin_i,
  output logic [N_PINS-1:0] rise_o
);

  localparam int LAST = STAGES - 1;

  for (genvar p = 0; p < N_PINS; p++) begin : g_lane
    logic [STAGES-1:0] chain_q;
    logic [STAGES-1:0] chain_d;
    logic              prev_q;

    always_comb begin
      chain_d = {chain_q[STAGES-2:0], pin_i[p]};
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        chain_q <= '0;
        prev_q  <= 1'b0;
      end else begin
        chain_q <= chain_d;
        prev_q  <= chain_q[LAST];
      end
    end

    assign rise_o[p] = chain_q[LAST] & ~prev_q;
  end

endmodule

// File: rtl/hsk_in_dbuf.sv
// Two-entry holding buffer with a data delay line aligned to the strobe synchronizer.
module hsk_in_dbuf #(
  parameter int DATA_W = 8,
  parameter int DLY    = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] din_i,
  input  logic              push_req_i,
  input  logic              pop_req_i,
  output logic              push_o,
  output logic [DATA_W-1:0] head_o,
  output logic [1:0]        cnt_o,
  output logic [1:0]        cnt_nxt_o
);

  localparam logic [1:0] FULL_CNT = 2'd2;

  // Delay line: byte sampled together with the first synchronizer flop.
  logic [DATA_W-1:0] dpipe_q [DLY];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DLY; i++) dpipe_q[i] <= '0;
    end else begin
      dpipe_q[0] <= din_i;
      for (int i = 1; i < DLY; i++) dpipe_q[i] <= dpipe_q[i-1];
    end
  end

  logic [DATA_W-1:0] slot0_q, slot1_q, slot0_d, slot1_d;
  logic [1:0]        cnt_q, cnt_d, cnt_after_pop;
  logic              pop, push;

  always_comb begin
    pop           = pop_req_i && (cnt_q != 2'd0);
    push          = push_req_i && ((cnt_q != FULL_CNT) || pop);
    cnt_after_pop = cnt_q - {1'b0, pop};
    slot0_d       = slot0_q;
    slot1_d       = slot1_q;
    if (pop && (cnt_q == FULL_CNT)) slot0_d = slot1_q;
    if (push) begin
      if (cnt_after_pop == 2'd0) slot0_d = dpipe_q[DLY-1];
      else                       slot1_d = dpipe_q[DLY-1];
    end
    cnt_d = cnt_after_pop + {1'b0, push};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot0_q <= '0;
      slot1_q <= '0;
      cnt_q   <= '0;
    end else begin
      slot0_q <= slot0_d;
      slot1_q <= slot1_d;
      cnt_q   <= cnt_d;
    end
  end

  assign push_o    = push;
  assign head_o    = slot0_q;
  assign cnt_o     = cnt_q;
  assign cnt_nxt_o = cnt_d;

  // R3: never more than two held bytes
  a_r3_depth_limit: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= FULL_CNT);

  // R5: full buffer without a read keeps both entries
  a_r5_full_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == FULL_CNT && !pop_req_i) |=> ($stable(slot0_q) && $stable(slot1_q)));

  // R4: read of an empty buffer changes nothing
  a_r4_empty_read: assert property (@(posedge clk) disable iff (!rst_n)
    (pop_req_i && cnt_q == 2'd0 && !push_req_i) |=> ($stable(slot0_q) && cnt_q == 2'd0));

endmodule

// File: rtl/hsk_in_aux_ctl.sv
// Auxiliary pin control: sticky edge status and interlocked ready output.
module hsk_in_aux_ctl
  import hsk_in_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  aux_mode_e mode_i,
  input  logic      en_i,
  input  logic      aux_rise_i,
  input  logic      clr_i,
  input  logic      cap_i,
  input  logic [1:0] cnt_nxt_i,
  output logic      rdy_o,
  output logic      st_o,
  output logic      aux_o,
  output logic      aux_oe_o
);

  logic st_q, st_d;
  logic rdy_q, rdy_d;

  always_comb begin
    if (!en_i || mode_i != AUX_EDGE_IN) st_d = 1'b0;
    else if (aux_rise_i)                st_d = 1'b1;
    else if (clr_i)                     st_d = 1'b0;
    else                                st_d = st_q;

    rdy_d = en_i && (mode_i == AUX_INTERLOCK) && !cap_i && (cnt_nxt_i < 2'd2);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= 1'b0;
      rdy_q <= 1'b0;
    end else begin
      st_q  <= st_d;
      rdy_q <= rdy_d;
    end
  end

  always_comb begin
    unique case (mode_i)
      AUX_FIX_HI:    aux_o = 1'b1;
      AUX_INTERLOCK: aux_o = rdy_q;
      default:       aux_o = 1'b0;
    endcase
    aux_oe_o = (mode_i != AUX_EDGE_IN);
  end

  assign rdy_o = rdy_q;
  assign st_o  = st_q & (mode_i == AUX_EDGE_IN);

  // R6: enabled edge-input rising edge sets the status
  a_r6_edge_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (en_i && mode_i == AUX_EDGE_IN && aux_rise_i) |=> st_q);

  // R7: disable clears the status
  a_r7_dis_clears: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |=> !st_q);

  // R9: ready drops after an accepted strobe
  a_r9_drop_after_cap: assert property (@(posedge clk) disable iff (!rst_n)
    cap_i |=> !rdy_q);

  // R11: disabled means ready low
  a_r11_dis_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
    !en_i |=> !rdy_q);

endmodule

// File: rtl/hsk_in_port.sv
module hsk_in_port
  import hsk_in_pkg::*;
#(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              strb_i,
  input  logic [DATA_W-1:0] strb_data_i,
  input  logic              aux_i,
  output logic              aux_o,
  output logic              aux_oe_o,
  input  logic [1:0]        reg_sel_i,
  input  logic              reg_rd_i,
  input  logic              reg_wr_i,
  input  logic [7:0]        reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o
);

  localparam int PIN_STRB = 0;
  localparam int PIN_AUX  = 1;

  // Reset: asserted asynchronously, released on the clock.
  logic [1:0] rsync_q;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_sync_n = rsync_q[1];

  // Control register
  logic      en_q, en_d;
  aux_mode_e mode_q, mode_d;
  logic      ctrl_we;

  always_comb begin
    ctrl_we = reg_wr_i && (reg_sel_i == SEL_CTRL);
    en_d    = en_q;
    mode_d  = mode_q;
    if (ctrl_we) begin
      en_d   = reg_wdata_i[CTRL_EN_BIT];
      mode_d = aux_mode_e'(reg_wdata_i[1:0]);
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      en_q   <= 1'b0;
      mode_q <= AUX_EDGE_IN;
    end else if (ctrl_we) begin
      en_q   <= en_d;
      mode_q <= mode_d;
    end
  end

  logic unused_wdata;
  assign unused_wdata = ^reg_wdata_i[6:2];

  // Pin synchronization
  logic [1:0] rise;

  hsk_in_sync #(.N_PINS(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk    (clk),
    .rst_n  (rst_sync_n),
    .pin_i  ({aux_i, strb_i}),
    .rise_o (rise)
  );

  // Holding buffer
  logic              rdy;
  logic              push_req, pop_req, push;
  logic [DATA_W-1:0] head;
  logic [1:0]        cnt, cnt_nxt;

  always_comb begin
    push_req = rise[PIN_STRB] && ((mode_q != AUX_INTERLOCK) || rdy);
    pop_req  = reg_rd_i && (reg_sel_i == SEL_DATA);
  end

  hsk_in_dbuf #(.DATA_W(DATA_W), .DLY(SYNC_STAGES)) u_dbuf (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .din_i      (strb_data_i),
    .push_req_i (push_req),
    .pop_req_i  (pop_req),
    .push_o     (push),
    .head_o     (head),
    .cnt_o      (cnt),
    .cnt_nxt_o  (cnt_nxt)
  );

  // Auxiliary pin
  logic aux_st, aux_clr;
  assign aux_clr = reg_wr_i && (reg_sel_i == SEL_STAT) && reg_wdata_i[STAT_AUX_BIT];

  hsk_in_aux_ctl u_aux (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .mode_i     (mode_q),
    .en_i       (en_q),
    .aux_rise_i (rise[PIN_AUX]),
    .clr_i      (aux_clr),
    .cap_i      (push),
    .cnt_nxt_i  (cnt_nxt),
    .rdy_o      (rdy),
    .st_o       (aux_st),
    .aux_o      (aux_o),
    .aux_oe_o   (aux_oe_o)
  );

  // Read mux
  always_comb begin
    reg_rdata_o = '0;
    unique case (reg_sel_i)
      SEL_CTRL: begin
        reg_rdata_o[CTRL_EN_BIT] = en_q;
        reg_rdata_o[1:0]         = mode_q;
      end
      SEL_STAT: begin
        reg_rdata_o[STAT_DP_BIT]  = (cnt != 2'd0);
        reg_rdata_o[STAT_AUX_BIT] = aux_st;
      end
      SEL_DATA: reg_rdata_o = head;
      default:  reg_rdata_o = '0;
    endcase
  end

  // R10: in interlocked mode, a strobe seen while ready is low adds nothing
  a_r10_ignore_not_ready: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (mode_q == AUX_INTERLOCK && !rdy && !pop_req) |=> (cnt <= $past(cnt)));

  // R1: output enable is off in edge-input mode
  a_r1_oe_edge_mode: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (mode_q == AUX_EDGE_IN) |-> !aux_oe_o);

endmodule

// File: tb/hsk_in_port_tb_top.sv
`timescale 1ns/1ps
module hsk_in_port_tb_top;

  logic       clk;
  logic       rst_n;
  logic       strb;
  logic [7:0] sdata;
  logic       aux_in;
  logic       aux_out, aux_oe;
  logic [1:0] sel;
  logic       rd, wr;
  logic [7:0] wdata, rdata;

  int n_chk;
  int n_fail;
  logic aux_snap;

  hsk_in_port dut_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .strb_i      (strb),
    .strb_data_i (sdata),
    .aux_i       (aux_in),
    .aux_o       (aux_out),
    .aux_oe_o    (aux_oe),
    .reg_sel_i   (sel),
    .reg_rd_i    (rd),
    .reg_wr_i    (wr),
    .reg_wdata_i (wdata),
    .reg_rdata_o (rdata)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic reg_write(input logic [1:0] s, input logic [7:0] d);
    @(negedge clk);
    sel = s; wdata = d; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0;
  endtask

  task automatic reg_read(input logic [1:0] s, output logic [7:0] v);
    @(negedge clk);
    sel = s; rd = 1'b1;
    #1 v = rdata;
    @(negedge clk);
    rd = 1'b0;
  endtask

  task automatic send_byte(input logic [7:0] b);
    @(negedge clk);
    sdata = b; strb = 1'b1;
    @(negedge clk);
    @(negedge clk);
    strb = 1'b0;
    @(negedge clk);
    aux_snap = aux_out;
    @(negedge clk);
  endtask

  task automatic pulse_aux();
    @(negedge clk); aux_in = 1'b1;
    @(negedge clk);
    @(negedge clk); aux_in = 1'b0;
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic t_reset();
    logic [7:0] v;
    reg_read(2'd0, v); check("R1 ctrl", v, 8'h00);
    reg_read(2'd1, v); check("R1 status", v, 8'h00);
    check("R1 oe", {7'd0, aux_oe}, 8'h00);
  endtask

  task automatic t_ctrl();
    logic [7:0] v;
    reg_write(2'd0, 8'h83);
    reg_read(2'd0, v); check("R12 readback 83", v, 8'h83);
    reg_write(2'd0, 8'h01);
    reg_read(2'd0, v); check("R12 readback 01", v, 8'h01);
  endtask

  task automatic t_fifo();
    logic [7:0] v;
    reg_write(2'd0, 8'h80);
    send_byte(8'hA1);
    reg_read(2'd1, v); check("R2 data present", v, 8'h01);
    send_byte(8'hB2);
    reg_read(2'd2, v); check("R3 first byte", v, 8'hA1);
    reg_read(2'd1, v); check("R3 still present", v, 8'h01);
    reg_read(2'd2, v); check("R3 second byte", v, 8'hB2);
    reg_read(2'd1, v); check("R3 empty status", v, 8'h00);
    reg_read(2'd2, v); check("R4 empty read value", v, 8'hB2);
    reg_read(2'd1, v); check("R4 empty status", v, 8'h00);
  endtask

  task automatic t_overflow();
    logic [7:0] v;
    send_byte(8'hC3);
    send_byte(8'hD4);
    send_byte(8'hE5);
    reg_read(2'd2, v); check("R5 first kept", v, 8'hC3);
    reg_read(2'd2, v); check("R5 second kept", v, 8'hD4);
    reg_read(2'd1, v); check("R5 third dropped", v, 8'h00);
  endtask

  task automatic t_aux_edge();
    logic [7:0] v;
    pulse_aux();
    reg_read(2'd1, v); check("R6 edge sets", v, 8'h02);
    reg_write(2'd1, 8'h00);
    reg_read(2'd1, v); check("R6 write 0 keeps", v, 8'h02);
    reg_write(2'd1, 8'h02);
    reg_read(2'd1, v); check("R6 write 1 clears", v, 8'h00);
    pulse_aux();
    reg_write(2'd0, 8'h00);
    reg_read(2'd1, v); check("R7 disable clears", v, 8'h00);
    pulse_aux();
    reg_read(2'd1, v); check("R7 disabled edge ignored", v, 8'h00);
    reg_write(2'd0, 8'h80);
    reg_read(2'd1, v); check("R7 reenable stays 0", v, 8'h00);
  endtask

  task automatic t_fixed();
    logic [7:0] v;
    reg_write(2'd0, 8'h81);
    @(negedge clk);
    check("R8 fixed low level", {7'd0, aux_out}, 8'h00);
    check("R8 fixed low oe", {7'd0, aux_oe}, 8'h01);
    pulse_aux();
    reg_read(2'd1, v); check("R8 status stays 0", v, 8'h00);
    reg_write(2'd0, 8'h82);
    @(negedge clk);
    check("R8 fixed high level", {7'd0, aux_out}, 8'h01);
    check("R8 fixed high oe", {7'd0, aux_oe}, 8'h01);
  endtask

  task automatic t_interlock();
    logic [7:0] v;
    reg_write(2'd0, 8'h03);
    @(negedge clk);
    check("R11 disabled ready low", {7'd0, aux_out}, 8'h00);
    send_byte(8'h5A);
    reg_read(2'd1, v); check("R10 strobe ignored while low", v, 8'h00);
    reg_write(2'd0, 8'h83);
    @(negedge clk);
    check("R9 ready when empty", {7'd0, aux_out}, 8'h01);
    send_byte(8'h11);
    check("R9 drop after strobe", {7'd0, aux_snap}, 8'h00);
    check("R9 ready again", {7'd0, aux_out}, 8'h01);
    send_byte(8'h22);
    check("R9 drop after second", {7'd0, aux_snap}, 8'h00);
    check("R9 low while full", {7'd0, aux_out}, 8'h00);
    send_byte(8'h33);
    check("R9 still low", {7'd0, aux_out}, 8'h00);
    reg_read(2'd2, v); check("R9 read oldest", v, 8'h11);
    check("R9 ready after read", {7'd0, aux_out}, 8'h01);
    reg_read(2'd2, v); check("R10 full strobe ignored", v, 8'h22);
    reg_read(2'd1, v); check("R10 nothing extra", v, 8'h00);
    reg_read(2'd2, v); check("R4 empty read in interlock", v, 8'h22);
  endtask

  bit done;

  initial begin
    n_chk = 0; n_fail = 0; done = 1'b0; aux_snap = 1'b0;
    rst_n = 1'b0; strb = 1'b0; sdata = '0; aux_in = 1'b0;
    sel = '0; rd = 1'b0; wr = 1'b0; wdata = '0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_ctrl();
    t_fifo();
    t_overflow();
    t_aux_edge();
    t_fixed();
    t_interlock();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

endmodule